// File: doc/BRIEF.md
# Pipelined Three-Product Complex Multiplier

This block forms the exact product of two complex numbers whose real and imaginary parts are signed fixed-point values. The first operand is `a_re + j*a_im` and the second is `b_re + j*b_im`. It needs only three real multiplications instead of the usual four. First it forms two pre-sums, one from the components of each operand. Then it multiplies the two real parts together, the two imaginary parts together, and the two pre-sums together. Two subtraction steps rebuild the real and imaginary results from these three products.

The datapath has three register stages: pre-add, multiply and post-subtract. It accepts a new operand pair on every clock. A valid strobe travels alongside the data, so each result appears exactly three clocks after its operands were presented. The outputs are wide enough that no combination of inputs can overflow, so there is no rounding and no saturation. The block suits butterfly and mixing datapaths that issue one complex multiply per cycle.

Top module: `cmul3_top`

## Requirements
- R1: While `rst_n` is low, and for the first three rising edges after it goes high, `out_valid` is 0. Reset also clears `prod_re` and `prod_im` to 0.
- R2: `out_valid` is high at the output after a rising edge exactly when `in_valid` was 1 at the rising edge three edges earlier.
- R3: A valid result has `prod_re` equal to `a_re*b_re - a_im*b_im`. It is exact and two's complement, and it is taken from the operands that entered three edges earlier.
- R4: A valid result has `prod_im` equal to `a_re*b_im + a_im*b_re`. It is exact and two's complement, and it is taken from the same operands as R3.
- R5: Operands presented with `in_valid` high on consecutive edges give results on consecutive edges, in the same order and with no gaps.
- R6: Operands that are all -32768 (the most negative 16-bit value), or that mix the extreme values, give exact results: `prod_im` = 2^31 for four -32768 inputs, with no wraparound.
- R7: While `out_valid` is 0, `prod_re` and `prod_im` keep the last delivered result, or 0 if no result has been delivered since reset. Operands presented with `in_valid` low have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair on this edge is to be multiplied |
| a_re | input | 16 | Real part of the first operand, signed |
| a_im | input | 16 | Imaginary part of the first operand, signed |
| b_re | input | 16 | Real part of the second operand, signed |
| b_im | input | 16 | Imaginary part of the second operand, signed |
| out_valid | output | 1 | `prod_re` and `prod_im` hold a new result |
| prod_re | output | 34 | Real part of the product, signed |
| prod_im | output | 34 | Imaginary part of the product, signed |

## Verification
A pre-sum that is too narrow, or a wrong sign extension, shows up only on extreme operands. It appears as a wrong `prod_im` on the third edge after those operands entered, which is why the corner operands are driven both in isolation and inside bursts. A misplaced valid bit shifts `out_valid` by one edge. The comparison made on every clock then catches a missing result or an unexpected one at once. A stage register that loads while its valid bit is low corrupts the held output during the next bubble, and the hold check reports it on that same cycle.

// File: rtl/cmul3_pkg.sv
package cmul3_pkg;

    // Default component width and the depth of the datapath pipeline
    localparam int DEF_IN_W   = 16;
    localparam int PIPE_DEPTH = 3;

    // The three real products, by slot
    localparam int NUM_PROD = 3;
    typedef enum logic [1:0] {
        SLOT_RR  = 2'd0,   // real * real
        SLOT_II  = 2'd1,   // imag * imag
        SLOT_SUM = 2'd2    // presum * presum
    } slot_e;

endpackage

// File: rtl/cmul3_preadd.sv
module cmul3_preadd
    import cmul3_pkg::*;
#(
    parameter int IN_W = DEF_IN_W,
    localparam int SUM_W = IN_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    v_in,
    input  logic signed [IN_W-1:0]  x_re,
    input  logic signed [IN_W-1:0]  x_im,
    input  logic signed [IN_W-1:0]  y_re,
    input  logic signed [IN_W-1:0]  y_im,
    output logic                    v_out,
    output logic signed [SUM_W-1:0] lhs_q [NUM_PROD],
    output logic signed [SUM_W-1:0] rhs_q [NUM_PROD]
);

    logic signed [SUM_W-1:0] lhs_d [NUM_PROD];
    logic signed [SUM_W-1:0] rhs_d [NUM_PROD];

    // Sign-extend to the presum width, so the sum of two extremes fits
    always_comb begin
        lhs_d[int'(SLOT_RR)]  = SUM_W'(x_re);
        rhs_d[int'(SLOT_RR)]  = SUM_W'(y_re);
        lhs_d[int'(SLOT_II)]  = SUM_W'(x_im);
        rhs_d[int'(SLOT_II)]  = SUM_W'(y_im);
        lhs_d[int'(SLOT_SUM)] = SUM_W'(x_re) + SUM_W'(x_im);
        rhs_d[int'(SLOT_SUM)] = SUM_W'(y_re) + SUM_W'(y_im);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_out <= 1'b0;
        end else begin
            v_out <= v_in;
        end
    end

    for (genvar g = 0; g < NUM_PROD; g++) begin : g_opnd
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lhs_q[g] <= '0;
                rhs_q[g] <= '0;
            end else if (v_in) begin
                lhs_q[g] <= lhs_d[g];
                rhs_q[g] <= rhs_d[g];
            end
        end
    end

endmodule

// File: rtl/cmul3_mult.sv
module cmul3_mult
    import cmul3_pkg::*;
#(
    parameter int SUM_W = DEF_IN_W + 1,
    localparam int PROD_W = 2 * SUM_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     v_in,
    input  logic signed [SUM_W-1:0]  lhs [NUM_PROD],
    input  logic signed [SUM_W-1:0]  rhs [NUM_PROD],
    output logic                     v_out,
    output logic signed [PROD_W-1:0] prod_q [NUM_PROD]
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_out <= 1'b0;
        end else begin
            v_out <= v_in;
        end
    end

    // One real multiplier per slot; three in all
    for (genvar g = 0; g < NUM_PROD; g++) begin : g_mul
        logic signed [PROD_W-1:0] full;
        assign full = PROD_W'(lhs[g]) * PROD_W'(rhs[g]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prod_q[g] <= '0;
            end else if (v_in) begin
                prod_q[g] <= full;
            end
        end
    end

endmodule

// File: rtl/cmul3_postsub.sv
module cmul3_postsub
    import cmul3_pkg::*;
#(
    parameter int PROD_W = 2 * (DEF_IN_W + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     v_in,
    input  logic signed [PROD_W-1:0] prod [NUM_PROD],
    output logic                     v_out,
    output logic signed [PROD_W-1:0] re_q,
    output logic signed [PROD_W-1:0] im_q
);

    logic signed [PROD_W-1:0] re_d;
    logic signed [PROD_W-1:0] im_d;
    logic signed [PROD_W-1:0] pair_sum;

    // real = rr - ii ; imag = presum product - rr - ii
    always_comb begin
        pair_sum = prod[int'(SLOT_RR)] + prod[int'(SLOT_II)];
        re_d     = prod[int'(SLOT_RR)] - prod[int'(SLOT_II)];
        im_d     = prod[int'(SLOT_SUM)] - pair_sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_out <= 1'b0;
            re_q  <= '0;
            im_q  <= '0;
        end else begin
            v_out <= v_in;
            if (v_in) begin
                re_q <= re_d;
                im_q <= im_d;
            end
        end
    end

endmodule

// File: rtl/cmul3_top.sv
module cmul3_top
    import cmul3_pkg::*;
#(
    parameter int IN_W = DEF_IN_W,
    localparam int SUM_W = IN_W + 1,
    localparam int OUT_W = 2 * SUM_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  a_re,
    input  logic signed [IN_W-1:0]  a_im,
    input  logic signed [IN_W-1:0]  b_re,
    input  logic signed [IN_W-1:0]  b_im,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] prod_re,
    output logic signed [OUT_W-1:0] prod_im
);

    logic                    s1_v;
    logic signed [SUM_W-1:0] s1_lhs [NUM_PROD];
    logic signed [SUM_W-1:0] s1_rhs [NUM_PROD];
    logic                    s2_v;
    logic signed [OUT_W-1:0] s2_prod [NUM_PROD];

    cmul3_preadd #(.IN_W(IN_W)) preadd_i (
        .clk   (clk),
        .rst_n (rst_n),
        .v_in  (in_valid),
        .x_re  (a_re),
        .x_im  (a_im),
        .y_re  (b_re),
        .y_im  (b_im),
        .v_out (s1_v),
        .lhs_q (s1_lhs),
        .rhs_q (s1_rhs)
    );

    cmul3_mult #(.SUM_W(SUM_W)) mult_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .v_in   (s1_v),
        .lhs    (s1_lhs),
        .rhs    (s1_rhs),
        .v_out  (s2_v),
        .prod_q (s2_prod)
    );

    cmul3_postsub #(.PROD_W(OUT_W)) postsub_i (
        .clk   (clk),
        .rst_n (rst_n),
        .v_in  (s2_v),
        .prod  (s2_prod),
        .v_out (out_valid),
        .re_q  (prod_re),
        .im_q  (prod_im)
    );

endmodule

// File: rtl/cmul3_chk.sv
module cmul3_chk #(
    parameter int IN_W = 16,
    localparam int OUT_W = 2 * (IN_W + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic signed [IN_W-1:0]  a_re,
    input logic signed [IN_W-1:0]  a_im,
    input logic signed [IN_W-1:0]  b_re,
    input logic signed [IN_W-1:0]  b_im,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] prod_re,
    input logic signed [OUT_W-1:0] prod_im
);

    // Edges seen since reset, saturating at the pipeline depth
    logic [1:0] seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= 2'd0;
        end else if (seen != 2'd3) begin
            seen <= seen + 2'd1;
        end
    end

    // Four-product reference, independent of the three-product datapath
    function automatic logic signed [OUT_W-1:0] ref_re(
        input logic signed [IN_W-1:0] p, q, r, s);
        return OUT_W'(p) * OUT_W'(r) - OUT_W'(q) * OUT_W'(s);
    endfunction

    function automatic logic signed [OUT_W-1:0] ref_im(
        input logic signed [IN_W-1:0] p, q, r, s);
        return OUT_W'(p) * OUT_W'(s) + OUT_W'(q) * OUT_W'(r);
    endfunction

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (seen != 2'd3) |-> !out_valid);

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    a_r3_real_part: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd3 && out_valid) |->
            (prod_re == ref_re($past(a_re, 3), $past(a_im, 3), $past(b_re, 3), $past(b_im, 3))));

    a_r4_imag_part: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd3 && out_valid) |->
            (prod_im == ref_im($past(a_re, 3), $past(a_im, 3), $past(b_re, 3), $past(b_im, 3))));

    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (seen != 2'd0 && !out_valid) |-> ($stable(prod_re) && $stable(prod_im)));

endmodule

bind cmul3_top cmul3_chk #(.IN_W(IN_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a_re      (a_re),
    .a_im      (a_im),
    .b_re      (b_re),
    .b_im      (b_im),
    .out_valid (out_valid),
    .prod_re   (prod_re),
    .prod_im   (prod_im)
);

// File: tb/cmul3_top_tb_top.sv
`timescale 1ns/1ps
module cmul3_top_tb_top;

    localparam int IN_W  = 16;
    localparam int OUT_W = 2 * (IN_W + 1);
    localparam int WATCHDOG = 20000;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic signed [IN_W-1:0]  a_re = '0, a_im = '0, b_re = '0, b_im = '0;
    logic                    out_valid;
    logic signed [OUT_W-1:0] prod_re, prod_im;

    always #2.5 clk = ~clk;

    cmul3_top #(.IN_W(IN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .out_valid(out_valid), .prod_re(prod_re), .prod_im(prod_im)
    );

    typedef struct {
        longint re;
        longint im;
        int     due;
        bit     corner;
    } exp_t;

    exp_t   pend[$];
    int     cyc = 0;
    int     checks = 0;
    int     errors = 0;
    int     pushed = 0;
    int     popped = 0;
    longint last_re = 0;
    longint last_im = 0;
    bit     done = 1'b0;

    function automatic bit is_corner(input logic signed [IN_W-1:0] v);
        return (v == -32768) || (v == 32767);
    endfunction

    // Reference model: four-product formula, queued with its due cycle
    always @(posedge clk) begin
        if (rst_n) begin
            if (in_valid) begin
                exp_t e;
                e.re  = longint'(a_re) * longint'(b_re) - longint'(a_im) * longint'(b_im);
                e.im  = longint'(a_re) * longint'(b_im) + longint'(a_im) * longint'(b_re);
                e.due = cyc + 3;
                e.corner = is_corner(a_re) || is_corner(a_im) || is_corner(b_re) || is_corner(b_im);
                pend.push_back(e);
                pushed++;
            end
            cyc <= cyc + 1;
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit due_now;
            due_now = (pend.size() != 0) && (pend[0].due == cyc);
            checks++;
            if (out_valid !== due_now) begin
                errors++;
                $display("FAIL R2 out_valid at cycle %0d actual %0b expected %0b", cyc, out_valid, due_now);
            end
            if (out_valid === 1'b1 && pend.size() != 0) begin
                exp_t e;
                e = pend.pop_front();
                popped++;
                checks++;
                if (longint'(prod_re) != e.re) begin
                    errors++;
                    if (e.corner) $display("FAIL R6 real actual %0d expected %0d", longint'(prod_re), e.re);
                    else          $display("FAIL R3 real actual %0d expected %0d", longint'(prod_re), e.re);
                end
                checks++;
                if (longint'(prod_im) != e.im) begin
                    errors++;
                    if (e.corner) $display("FAIL R6 imag actual %0d expected %0d", longint'(prod_im), e.im);
                    else          $display("FAIL R4 imag actual %0d expected %0d", longint'(prod_im), e.im);
                end
                last_re = e.re;
                last_im = e.im;
            end else if (out_valid !== 1'b1) begin
                checks++;
                if (longint'(prod_re) != last_re || longint'(prod_im) != last_im) begin
                    errors++;
                    $display("FAIL R7 held output actual %0d/%0d expected %0d/%0d",
                             longint'(prod_re), longint'(prod_im), last_re, last_im);
                end
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic issue(input int p, input int q, input int r, input int s, input bit v);
        @(negedge clk);
        a_re = IN_W'(p); a_im = IN_W'(q); b_re = IN_W'(r); b_im = IN_W'(s);
        in_valid = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) issue($urandom, $urandom, $urandom, $urandom, 1'b0);
    endtask

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || prod_re !== '0 || prod_im !== '0) begin
            errors++;
            $display("FAIL R1 reset state actual %0b/%0d/%0d expected 0/0/0", out_valid, prod_re, prod_im);
        end
        rst_n = 1'b1;
        // R7: data with in_valid low changes nothing
        idle(6);
        // R3/R4: single operation
        issue(3, 4, 5, 6, 1'b1);
        idle(5);
        // R6: extreme operands, isolated
        issue(-32768, -32768, -32768, -32768, 1'b1);
        idle(4);
        issue(32767, 32767, 32767, 32767, 1'b1);
        idle(4);
        // R6 and R5: extremes back to back
        issue(-32768, 32767, -32768, 32767, 1'b1);
        issue(32767, -32768, -32768, 32767, 1'b1);
        issue(-32768, -32768, 32767, 32767, 1'b1);
        issue(-32768, 0, 0, -32768, 1'b1);
        issue(0, -32768, -32768, 0, 1'b1);
        issue(-1, -1, -1, -1, 1'b1);
        idle(4);
        // R5: long random burst
        for (int i = 0; i < 300; i++) issue($urandom, $urandom, $urandom, $urandom, 1'b1);
        // R7 and R2: bubbles
        for (int i = 0; i < 300; i++) issue($urandom, $urandom, $urandom, $urandom, 1'(i % 3 == 0));
        for (int i = 0; i < 300; i++) issue($urandom, $urandom, $urandom, $urandom, 1'($urandom % 2));
        idle(8);
        // R5: every accepted operand produced exactly one result
        checks++;
        if (pushed != popped || pend.size() != 0) begin
            errors++;
            $display("FAIL R5 result count actual %0d expected %0d", popped, pushed);
        end
        finish_run();
    end

endmodule